// File: doc/BRIEF.md
# 4:4:4 to 4:2:2 Chroma Subsampler

This block sits in a video output path between a colour source that produces full-resolution 4:4:4 pixels and a narrow video interface that carries 4:2:2 samples. Each input pixel holds three components of `COMP_W` bits: red-difference chroma in the top field, luma in the middle field and blue-difference chroma in the bottom field. The pixel arrives together with a data-enable flag and horizontal and vertical sync flags. In normal operation, each active pixel leaves as a two-component word. The word holds the pixel's own luma and one chroma value. The chroma value alternates between the two chroma components from one active pixel to the next.

Each chroma value sent is the average of that component over the current pixel and the pixel of the previous clock cycle, with the half unit rounded up. The build-time parameter `CR_FIRST` chooses which chroma component opens every active run: 1 for red-difference, 0 for blue-difference. The chroma phase restarts on every rising edge of data-enable, so all lines begin alike whatever the length of the line before.

A runtime bypass input forwards the full 24-bit pixel unchanged. This lets a test pattern reach the transmitter without any alteration. The data path, the bypass path and the sync flags all pass through the same two register stages, so they stay aligned.

Top module: `yc422_subsampler`

## Requirements
- R1: While `rst_n` is low, and afterwards until non-zero inputs arrive, every output is zero.
- R2: `out_de`, `out_hsync` and `out_vsync` equal `in_de`, `in_hsync` and `in_vsync` from exactly two clock edges earlier.
- R3: With bypass off and data-enable high, `out_pix[15:8]` is the luma (`in_pix[15:8]`) of the pixel presented two edges earlier, and `out_pix[23:16]` is zero.
- R4: With bypass off and data-enable high, `out_pix[7:0]` is (c_cur + c_prev + 1) >> 1. Here c is the chroma component chosen for that pixel, taken from the current pixel and from the pixel presented in the previous clock cycle, whether that cycle was active or blanking. After reset the previous pixel counts as zero.
- R5: Within one run of active pixels, consecutive outputs carry the two chroma components in strict alternation.
- R6: The first active pixel after every rising edge of data-enable carries the component that `CR_FIRST` selects: `in_pix[23:16]` (red-difference) when `CR_FIRST` is 1, `in_pix[7:0]` (blue-difference) when it is 0. This holds after lines of odd and of even length.
- R7: With bypass off and data-enable low, `out_pix` is zero.
- R8: `bypass_en` is sampled together with the pixel. When it is high, `out_pix` equals the full 24-bit `in_pix` of two edges earlier, in active and in blanking cycles alike.
- R9: Extreme component values (0x00 next to 0xFF, 0xFF next to 0xFF) average without overflow: 0x80 and 0xFF respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Forward the pixel unchanged, sampled with the pixel |
| in_de | input | 1 | Input data-enable |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_pix | input | 3*COMP_W (24) | 4:4:4 pixel: red-difference, luma, blue-difference, top to bottom |
| out_de | output | 1 | Delayed data-enable |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_pix | output | 3*COMP_W (24) | 4:2:2 word in the low 16 bits, or the full pixel in bypass |

## Verification
The two-edge checks on syncs, luma and bypass data assume that the inputs are driven to defined values in every cycle once reset is released, including blanking cycles. The averaging rule of R4 also depends on the pixel of every cycle, so the stimulus drives each input on every clock, pixel values included.

The alternation check assumes that data-enable is the only thing that restarts the chroma phase. The stimulus therefore changes `bypass_en` only inside blanking, so that no line mixes the two modes. Two instances, one for each `CR_FIRST` setting, receive identical stimulus. The stimulus mixes random pixels, ramps and saturated extremes over lines of length 1, 4, 5 and 8.

// File: rtl/yc422_pkg.sv
package yc422_pkg;
   // which of the two chroma components a word carries
   typedef enum logic {
      SEL_FIRST  = 1'b0,
      SEL_SECOND = 1'b1
   } csel_e;

   // side-band bits travelling with a pixel: de, hsync, vsync, bypass
   localparam int unsigned SIDE_W = 4;
endpackage

// File: rtl/yc422_pipe.sv
module yc422_pipe #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [DEPTH-1:0][W-1:0] st_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("yc422_pipe: W must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("yc422_pipe: DEPTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q[0] <= d;
         for (int i = 1; i < int'(DEPTH); i++) begin
            st_q[i] <= st_q[i-1];
         end
      end
   end

   assign q = st_q[DEPTH-1];
endmodule

// File: rtl/yc422_chroma_avg.sv
module yc422_chroma_avg #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prv,
   output logic [W-1:0] avg
);
   logic [W:0] sum;

   assign sum = {1'b0, cur} + {1'b0, prv} + {{W{1'b0}}, 1'b1};
   assign avg = sum[W:1];

   // R4 / R9: a mean never leaves the range spanned by its two inputs
   always_comb begin
      if (!$isunknown({cur, prv})) begin
         a_r9_avg_in_range: assert ((avg >= ((cur < prv) ? cur : prv)) &&
                                    (avg <= ((cur < prv) ? prv : cur)));
      end
   end
endmodule

// File: rtl/yc422_phase.sv
module yc422_phase
   import yc422_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  de_i,
   output csel_e sel_o
);
   logic  de_prev_q;
   csel_e ph_q;

   assign sel_o = (de_i && !de_prev_q) ? SEL_FIRST : ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         de_prev_q <= 1'b0;
         ph_q      <= SEL_FIRST;
      end else begin
         de_prev_q <= de_i;
         if (de_i) begin
            ph_q <= (sel_o == SEL_FIRST) ? SEL_SECOND : SEL_FIRST;
         end
      end
   end

   // R5: inside an active run the component flips on every pixel
   a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (de_i && de_prev_q) |-> (sel_o != $past(sel_o)));
endmodule

// File: rtl/yc422_subsampler.sv
module yc422_subsampler
   import yc422_pkg::*;
#(
   parameter int unsigned COMP_W   = 8,
   parameter int unsigned CR_FIRST = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bypass_en,
   input  logic                in_de,
   input  logic                in_hsync,
   input  logic                in_vsync,
   input  logic [3*COMP_W-1:0] in_pix,
   output logic                out_de,
   output logic                out_hsync,
   output logic                out_vsync,
   output logic [3*COMP_W-1:0] out_pix
);
   localparam int unsigned PIX_W = 3 * COMP_W;
   localparam int unsigned OUT_W = 2 * COMP_W;
   localparam int unsigned A_W   = PIX_W + SIDE_W;

   generate
      if (COMP_W < 2) begin : g_bad_comp
         $error("yc422_subsampler: COMP_W must be at least 2");
      end
      if (CR_FIRST > 1) begin : g_bad_order
         $error("yc422_subsampler: CR_FIRST must be 0 or 1");
      end
   endgenerate

   // ---------------- stage A: capture pixel and side-band ----------------
   logic [PIX_W-1:0] a_pix, p_pix;
   logic             a_de, a_hs, a_vs, a_byp;

   yc422_pipe #(.W(A_W), .DEPTH(1)) u_stage_a (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_pix, in_de, in_hsync, in_vsync, bypass_en}),
      .q     ({a_pix, a_de, a_hs, a_vs, a_byp})
   );

   // pixel of the previous cycle, for the two-tap chroma mean
   yc422_pipe #(.W(PIX_W), .DEPTH(1)) u_prev (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (a_pix),
      .q     (p_pix)
   );

   // ---------------- chroma means: index 0 = blue-diff, 1 = red-diff -----
   logic [1:0][COMP_W-1:0] c_avg;

   generate
      for (genvar c = 0; c < 2; c++) begin : g_avg
         localparam int unsigned LSB = c * OUT_W;
         yc422_chroma_avg #(.W(COMP_W)) u_avg (
            .cur (a_pix[LSB +: COMP_W]),
            .prv (p_pix[LSB +: COMP_W]),
            .avg (c_avg[c])
         );
      end
   endgenerate

   logic [COMP_W-1:0] c_first, c_second;

   generate
      if (CR_FIRST == 1) begin : g_cr_first
         assign c_first  = c_avg[1];
         assign c_second = c_avg[0];
      end else begin : g_cb_first
         assign c_first  = c_avg[0];
         assign c_second = c_avg[1];
      end
   endgenerate

   csel_e sel;

   yc422_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .de_i  (a_de),
      .sel_o (sel)
   );

   // ---------------- stage B: output word ----------------
   logic [COMP_W-1:0] chroma;
   logic [PIX_W-1:0]  word_nx;

   assign chroma = (sel == SEL_FIRST) ? c_first : c_second;

   always_comb begin
      if (a_byp) begin
         word_nx = a_pix;
      end else if (a_de) begin
         word_nx = {{COMP_W{1'b0}}, a_pix[COMP_W +: COMP_W], chroma};
      end else begin
         word_nx = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pix   <= '0;
         out_de    <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
      end else begin
         out_pix   <= word_nx;
         out_de    <= a_de;
         out_hsync <= a_hs;
         out_vsync <= a_vs;
      end
   end

   // ---------------- assertions ----------------
   logic [1:0] live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (live_q != 2'd2) begin
         live_q <= live_q + 2'd1;
      end
   end

   a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q == 2'd2) |->
         ({out_de, out_hsync, out_vsync} ==
          $past({in_de, in_hsync, in_vsync}, 2)));

   a_r8_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q == 2'd2 && $past(bypass_en, 2)) |-> (out_pix == $past(in_pix, 2)));

   a_r3_luma_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q == 2'd2 && out_de && !$past(bypass_en, 2)) |->
         (out_pix[PIX_W-1:COMP_W] ==
          {{COMP_W{1'b0}}, $past(in_pix[COMP_W +: COMP_W], 2)}));

   a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q == 2'd2 && !out_de && !$past(bypass_en, 2)) |-> (out_pix == '0));
endmodule

// File: tb/tb_yc422_subsampler.sv
module tb_yc422_subsampler;
   localparam int CW = 8;
   localparam int PW = 3 * CW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bypass_en = 1'b0, in_de = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
   logic [PW-1:0] in_pix = '0;
   logic o0_de, o0_hs, o0_vs, o1_de, o1_hs, o1_vs;
   logic [PW-1:0] o0_pix, o1_pix;

   always #2.5 clk = ~clk;

   yc422_subsampler #(.COMP_W(CW), .CR_FIRST(0)) dut (
      .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .in_de(in_de),
      .in_hsync(in_hsync), .in_vsync(in_vsync), .in_pix(in_pix),
      .out_de(o0_de), .out_hsync(o0_hs), .out_vsync(o0_vs), .out_pix(o0_pix));

   yc422_subsampler #(.COMP_W(CW), .CR_FIRST(1)) dut_cr (
      .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .in_de(in_de),
      .in_hsync(in_hsync), .in_vsync(in_vsync), .in_pix(in_pix),
      .out_de(o1_de), .out_hsync(o1_hs), .out_vsync(o1_vs), .out_pix(o1_pix));

   typedef struct {
      int          due;
      logic [2:0]  side;
      logic [PW-1:0] d0;
      logic [PW-1:0] d1;
      int          tag;   // 0 bypass, 1 blank, 2 mid-line, 3 second pixel, 4 line start
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // model state
   logic [PW-1:0] m_prev = '0;
   bit            m_de_prev = 1'b0;
   bit            m_ph = 1'b0;
   int            m_pos = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [CW-1:0] mean(logic [CW-1:0] a, logic [CW-1:0] b);
      logic [CW:0] s;
      s = {1'b0, a} + {1'b0, b} + 1;
      return s[CW:1];
   endfunction

   // driver: one call per clock cycle, pushes the expected result
   task automatic drive(bit de, bit hs, bit vs, logic [PW-1:0] pix, bit byp);
      exp_t e;
      bit   first, sel;
      logic [CW-1:0] cb, cr, y;
      @(negedge clk);
      in_de = de; in_hsync = hs; in_vsync = vs; in_pix = pix; bypass_en = byp;
      first = de && !m_de_prev;
      sel   = first ? 1'b0 : m_ph;
      if (de) m_ph = ~sel;
      if (first) m_pos = 0;
      else if (de) m_pos++;
      cb = mean(pix[CW-1:0], m_prev[CW-1:0]);
      cr = mean(pix[PW-1:2*CW], m_prev[PW-1:2*CW]);
      y  = pix[2*CW-1:CW];
      e.due  = cyc + 2;
      e.side = {de, hs, vs};
      if (byp) begin
         e.d0 = pix; e.d1 = pix; e.tag = 0;
      end else if (!de) begin
         e.d0 = '0; e.d1 = '0; e.tag = 1;
      end else begin
         e.d0 = {{CW{1'b0}}, y, (sel == 1'b0) ? cb : cr};
         e.d1 = {{CW{1'b0}}, y, (sel == 1'b0) ? cr : cb};
         e.tag = (m_pos == 0) ? 4 : (m_pos == 1) ? 3 : 2;
      end
      exp_q.push_back(e);
      m_prev = pix;
      m_de_prev = de;
   endtask

   // monitor: compares both instances when an item falls due
   always @(posedge clk) begin
      #1;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         chk("R2 sync delay cb-first", {21'd0, o0_de, o0_hs, o0_vs}, {21'd0, e.side});
         chk("R2 sync delay cr-first", {21'd0, o1_de, o1_hs, o1_vs}, {21'd0, e.side});
         case (e.tag)
            0: begin
               chk("R8 bypass cb-first", o0_pix, e.d0);
               chk("R8 bypass cr-first", o1_pix, e.d1);
            end
            1: begin
               chk("R7 blank zero cb-first", o0_pix, e.d0);
               chk("R7 blank zero cr-first", o1_pix, e.d1);
            end
            default: begin
               chk("R3 luma/upper cb-first", {8'd0, o0_pix[PW-1:CW]}, {8'd0, e.d0[PW-1:CW]});
               chk("R3 luma/upper cr-first", {8'd0, o1_pix[PW-1:CW]}, {8'd0, e.d1[PW-1:CW]});
               if (e.tag == 4) begin
                  chk("R6 line start cb-first", {16'd0, o0_pix[CW-1:0]}, {16'd0, e.d0[CW-1:0]});
                  chk("R6 line start cr-first", {16'd0, o1_pix[CW-1:0]}, {16'd0, e.d1[CW-1:0]});
               end else if (e.tag == 3) begin
                  chk("R5 alternation cb-first", {16'd0, o0_pix[CW-1:0]}, {16'd0, e.d0[CW-1:0]});
                  chk("R5 alternation cr-first", {16'd0, o1_pix[CW-1:0]}, {16'd0, e.d1[CW-1:0]});
               end else begin
                  chk("R4 chroma mean cb-first", {16'd0, o0_pix[CW-1:0]}, {16'd0, e.d0[CW-1:0]});
                  chk("R4 chroma mean cr-first", {16'd0, o1_pix[CW-1:0]}, {16'd0, e.d1[CW-1:0]});
               end
            end
         endcase
      end
   end

   task automatic blank(int n, bit hs, bit vs, bit byp);
      for (int i = 0; i < n; i++) drive(1'b0, hs, vs, PW'($urandom), byp);
   endtask

   // mode 0 random, 1 extremes (R9), 2 ramp
   task automatic line(int n, int mode, bit byp);
      blank(2, 1'b1, 1'b0, byp);
      blank(1, 1'b0, 1'b0, byp);
      for (int i = 0; i < n; i++) begin
         logic [PW-1:0] p;
         case (mode)
            1: p = (i % 3 == 2) ? 24'hFFFFFF : ((i % 2 == 0) ? 24'h00FF00 : 24'hFF00FF);
            2: p = {8'(i * 17), 8'(i * 9 + 3), 8'(255 - i * 13)};
            default: p = PW'($urandom);
         endcase
         drive(1'b1, 1'b0, 1'b0, p, byp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs cb-first", {o0_pix[20:0], o0_de, o0_hs, o0_vs}, '0);
      chk("R1 reset outputs cr-first", {o1_pix[20:0], o1_de, o1_hs, o1_vs}, '0);
      chk("R1 reset upper bits", {o0_pix[23:21], o1_pix[23:21], 18'd0}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", o0_pix | o1_pix, '0);
      repeat (3) drive(1'b0, 1'b0, 1'b0, '0, 1'b0);
      line(5, 0, 1'b0);   // odd length
      line(4, 2, 1'b0);   // even length
      line(1, 0, 1'b0);   // single pixel
      line(8, 1, 1'b0);   // R9 extremes
      blank(3, 1'b0, 1'b1, 1'b0);
      line(7, 0, 1'b0);
      line(6, 2, 1'b1);   // R8 bypass line with its blanking
      blank(2, 1'b0, 1'b0, 1'b1);
      blank(2, 1'b0, 1'b0, 1'b0);
      line(5, 0, 1'b0);
      for (int k = 0; k < 4; k++) line(3 + k, k % 3, 1'b0);
      blank(4, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule